// File: doc/BRIEF.md
# Packed Lane Saturating Adder

This block adds two 128-bit vectors lane by lane in a single operation. The lane width is chosen at run time from 8, 16, 32 or 64 bits, so one vector holds sixteen, eight, four or two independent elements. Carries stop at every lane boundary that the current width sets. No lane's sum reaches a neighbouring lane.

A mode input picks the overflow behaviour of every lane at once. Modular addition keeps the low bits of each sum. Signed saturation clamps a lane that overflows to the most positive or most negative two's-complement value of that lane. Unsigned saturation clamps a lane that carries out to all ones. An operation is offered by raising `in_valid_i` for one cycle. One clock later the registered result appears together with `out_valid_o`. A new operation can be offered on every cycle.

Top module: `simd_sat_adder`

## Requirements
- R1: While `rst_ni` is low, `out_valid_o` is 0 and `result_o` is all zeros.
- R2: `out_valid_o` is high in the cycle after a cycle with `in_valid_i` high, and low in the cycle after a cycle with `in_valid_i` low.
- R3: A cycle with `in_valid_i` low leaves `result_o` unchanged in the next cycle.
- R4: `width_i` selects the lane size. 2'b00 gives 16 lanes of 8 bits, 2'b01 gives 8 lanes of 16 bits, 2'b10 gives 4 lanes of 32 bits, and 2'b11 gives 2 lanes of 64 bits. Lane k occupies bits [k*W +: W].
- R5: The carry out of one lane never enters the next lane, in any width or mode.
- R6: With `mode_i` = 2'b00 each lane result is the sum of its two operand lanes modulo 2^W.
- R7: With `mode_i` = 2'b01 a lane whose operands share a sign and whose sum has the other sign yields 0111..1 when both operands are non-negative and 1000..0 when both are negative. Any other lane yields the exact sum.
- R8: With `mode_i` = 2'b10 a lane whose unsigned sum exceeds 2^W-1 yields all ones.
- R9: With `mode_i` = 2'b10 a lane whose unsigned sum fits in W bits yields that exact sum.
- R10: `mode_i` = 2'b11 behaves exactly like 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands and controls are taken this cycle |
| width_i | input | 2 | Lane size select |
| mode_i | input | 2 | Overflow behaviour select |
| a_i | input | 128 | First operand vector |
| b_i | input | 128 | Second operand vector |
| out_valid_o | output | 1 | Result register holds a new result |
| result_o | output | 128 | Registered lane results |

## Verification
The assertions assume that the operands and controls are known, and not X, in every cycle where `in_valid_i` is high. They also assume that `in_valid_i` is low for as long as `rst_ni` is low. The stimulus holds every input low during reset and changes inputs only on the falling clock edge. It draws each operand, width and mode from a seeded generator and pushes random operands toward lane sign bits and all-ones lanes, so that both saturation directions and carries across lane boundaries appear often in every width.

// File: rtl/simd_sat_pkg.sv
package simd_sat_pkg;

  typedef enum logic [1:0] {
    LW_8  = 2'd0,
    LW_16 = 2'd1,
    LW_32 = 2'd2,
    LW_64 = 2'd3
  } lane_w_e;

  typedef enum logic [1:0] {
    MD_WRAP     = 2'd0,
    MD_SSAT     = 2'd1,
    MD_USAT     = 2'd2,
    MD_WRAP_ALT = 2'd3
  } sat_mode_e;

  // slices per lane minus one, as a mask over the slice index
  function automatic logic [7:0] span_mask(input logic [1:0] w);
    return 8'((8'd1 << w) - 8'd1);
  endfunction

endpackage

// File: rtl/simd_seg_adder.sv
module simd_seg_adder
  import simd_sat_pkg::*;
#(
  parameter int DATA_W  = 128,
  parameter int SLICE_W = 8,
  localparam int NS     = DATA_W / SLICE_W,
  localparam int IDX_W  = $clog2(NS)
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        width_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [NS-1:0]     cout_o,
  output logic [NS-1:0]     lane_top_o,
  output logic [NS-1:0]     a_msb_o,
  output logic [NS-1:0]     b_msb_o
);

  logic [IDX_W-1:0] span_m;
  assign span_m = IDX_W'(span_mask(width_i));

  for (genvar i = 0; i < NS; i++) begin : g_slice
    localparam logic [IDX_W-1:0] IDX = IDX_W'(i);
    localparam logic [IDX_W-1:0] NXT = IDX_W'(i + 1);
    logic               cin;
    logic [SLICE_W-1:0] as, bs, ss;

    assign as = a_i[i*SLICE_W +: SLICE_W];
    assign bs = b_i[i*SLICE_W +: SLICE_W];

    if (i == 0) begin : g_first
      assign cin = 1'b0;
    end else begin : g_rest
      logic lane_start;
      // break the chain where a new lane begins
      assign lane_start = (IDX & span_m) == '0;
      assign cin        = lane_start ? 1'b0 : cout_o[i-1];
    end

    assign {cout_o[i], ss} = {1'b0, as} + {1'b0, bs} + {{SLICE_W{1'b0}}, cin};
    assign sum_o[i*SLICE_W +: SLICE_W] = ss;
    assign lane_top_o[i] = (NXT & span_m) == '0;
    assign a_msb_o[i]    = as[SLICE_W-1];
    assign b_msb_o[i]    = bs[SLICE_W-1];
  end

endmodule

// File: rtl/simd_lane_clamp.sv
module simd_lane_clamp
  import simd_sat_pkg::*;
#(
  parameter int DATA_W  = 128,
  parameter int SLICE_W = 8,
  localparam int NS     = DATA_W / SLICE_W,
  localparam int IDX_W  = $clog2(NS)
) (
  input  logic [DATA_W-1:0] sum_i,
  input  logic [NS-1:0]     cout_i,
  input  logic [NS-1:0]     lane_top_i,
  input  logic [NS-1:0]     a_msb_i,
  input  logic [NS-1:0]     b_msb_i,
  input  logic [1:0]        width_i,
  input  logic [1:0]        mode_i,
  output logic [DATA_W-1:0] res_o
);

  logic [IDX_W-1:0] span_m;
  logic [NS-1:0]    s_ovf, u_ovf;

  assign span_m = IDX_W'(span_mask(width_i));

  // overflow is only meaningful at the top slice of a lane
  for (genvar i = 0; i < NS; i++) begin : g_flag
    logic s_msb;
    assign s_msb    = sum_i[i*SLICE_W + SLICE_W - 1];
    assign s_ovf[i] = lane_top_i[i] & (a_msb_i[i] == b_msb_i[i]) & (s_msb != a_msb_i[i]);
    assign u_ovf[i] = lane_top_i[i] & cout_i[i];
  end

  for (genvar i = 0; i < NS; i++) begin : g_sel
    localparam logic [IDX_W-1:0] IDX = IDX_W'(i);
    logic [IDX_W-1:0]   own;
    logic               neg;
    logic [SLICE_W-1:0] res;

    assign own = IDX | span_m;
    assign neg = a_msb_i[own];

    always_comb begin
      res = sum_i[i*SLICE_W +: SLICE_W];
      unique case (sat_mode_e'(mode_i))
        MD_SSAT: if (s_ovf[own]) begin
          res = lane_top_i[i] ? {neg, {(SLICE_W-1){~neg}}} : {SLICE_W{~neg}};
        end
        MD_USAT: if (u_ovf[own]) res = {SLICE_W{1'b1}};
        default: ;
      endcase
    end

    assign res_o[i*SLICE_W +: SLICE_W] = res;
  end

endmodule

// File: rtl/simd_out_stage.sv
module simd_out_stage #(
  parameter int DATA_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= data_i;
    end
  end

endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
  import simd_sat_pkg::*;
#(
  parameter int DATA_W  = 128,
  parameter int SLICE_W = 8,
  localparam int NS     = DATA_W / SLICE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [1:0]        width_i,
  input  logic [1:0]        mode_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] result_o
);

  logic [DATA_W-1:0] sum, res;
  logic [NS-1:0]     cout, lane_top, a_msb, b_msb;

  simd_seg_adder #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_add (
    .a_i       (a_i),
    .b_i       (b_i),
    .width_i   (width_i),
    .sum_o     (sum),
    .cout_o    (cout),
    .lane_top_o(lane_top),
    .a_msb_o   (a_msb),
    .b_msb_o   (b_msb)
  );

  simd_lane_clamp #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_clamp (
    .sum_i     (sum),
    .cout_i    (cout),
    .lane_top_i(lane_top),
    .a_msb_i   (a_msb),
    .b_msb_i   (b_msb),
    .width_i   (width_i),
    .mode_i    (mode_i),
    .res_o     (res)
  );

  simd_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(in_valid_i),
    .data_i (res),
    .valid_o(out_valid_o),
    .data_o (result_o)
  );

endmodule

// File: rtl/simd_sat_adder_chk.sv
module simd_sat_adder_chk #(
  parameter int DATA_W = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [1:0]        width_i,
  input logic [1:0]        mode_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] result_o
);

  function automatic logic bytes_floor(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b,
                                       input logic [DATA_W-1:0] r);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < DATA_W / 8; k++) begin
      if (r[k*8 +: 8] < a[k*8 +: 8] || r[k*8 +: 8] < b[k*8 +: 8]) ok = 1'b0;
    end
    return ok;
  endfunction

  logic [DATA_W-1:0] a_q, b_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) reset_clear_chk: assert (!out_valid_o && result_o == '0);
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  // R2
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  // R3
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(result_o));

  // R6
  wrap_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && (mode_i == 2'd0 || mode_i == 2'd3)
    |=> result_o[7:0] == 8'($past(a_i[7:0]) + $past(b_i[7:0])));

  // R7
  ssat_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && mode_i == 2'd1 && a_i[DATA_W-1] && b_i[DATA_W-1] |=> result_o[DATA_W-1]);

  // R8
  usat_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && mode_i == 2'd2 && width_i == 2'd0 |=> bytes_floor(a_q, b_q, result_o));

endmodule

bind simd_sat_adder simd_sat_adder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .width_i    (width_i),
  .mode_i     (mode_i),
  .a_i        (a_i),
  .b_i        (b_i),
  .out_valid_o(out_valid_o),
  .result_o   (result_o)
);

// File: tb/simd_sat_adder_tb.sv
module simd_sat_adder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 128;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid_i = 1'b0;
  logic [1:0]    width_i = '0;
  logic [1:0]    mode_i = '0;
  logic [DW-1:0] a_i = '0;
  logic [DW-1:0] b_i = '0;
  logic          out_valid_o;
  logic [DW-1:0] result_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  simd_sat_adder dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .width_i    (width_i),
    .mode_i     (mode_i),
    .a_i        (a_i),
    .b_i        (b_i),
    .out_valid_o(out_valid_o),
    .result_o   (result_o)
  );

  function automatic logic [DW-1:0] ref_add(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                            input logic [1:0] w, input logic [1:0] m);
    logic [DW-1:0] r;
    logic [63:0]   mask, x, y, lo;
    logic [64:0]   s;
    int            lw, n;
    r  = '0;
    lw = 8 << w;
    n  = DW / lw;
    mask = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
    for (int k = 0; k < n; k++) begin
      x  = 64'(a >> (k*lw)) & mask;
      y  = 64'(b >> (k*lw)) & mask;
      s  = {1'b0, x} + {1'b0, y};
      lo = s[63:0] & mask;
      if (m == 2'd1) begin
        if (x[lw-1] == y[lw-1] && lo[lw-1] != x[lw-1])
          lo = x[lw-1] ? (64'd1 << (lw-1)) : (mask >> 1);
      end else if (m == 2'd2) begin
        if (s[lw]) lo = mask;
      end
      r = r | (DW'(lo) << (k*lw));
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one operation, then one idle cycle
  task automatic run_op(input string req, input logic [DW-1:0] a, input logic [DW-1:0] b,
                        input logic [1:0] w, input logic [1:0] m, input logic [DW-1:0] exp);
    logic [DW-1:0] held;
    @(negedge clk_i);
    a_i = a; b_i = b; width_i = w; mode_i = m; in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    a_i = ~a; b_i = b ^ {4{32'h5a5a_a5a5}};
    check("R2 valid", DW'(out_valid_o), DW'(1));
    check(req, result_o, exp);
    held = result_o;
    @(negedge clk_i);
    check("R2 idle valid", DW'(out_valid_o), DW'(0));
    check("R3 hold", result_o, held);
  endtask

  function automatic logic [DW-1:0] rnd_vec();
    logic [DW-1:0] v;
    v = {$urandom, $urandom, $urandom, $urandom};
    case ($urandom % 4)
      0: v = v | {16{8'h80}};
      1: v = v | {$urandom, $urandom, $urandom, $urandom};
      2: v = v & ~{16{8'h80}};
      default: ;
    endcase
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] ones;
    void'($urandom(32'd20240611));
    ones = '1;
    repeat (3) @(negedge clk_i);
    // R1
    check("R1 reset valid", DW'(out_valid_o), DW'(0));
    check("R1 reset result", result_o, '0);
    rst_ni = 1'b1;

    // R4 R5: a single carry into lane 0 must stop at the lane edge
    for (int w = 0; w < 4; w++) begin
      run_op("R4 R5 lane edge", ones, DW'(1), 2'(w), 2'd0, ones << (8 << w));
    end
    // R5 every lane wraps to zero, nothing spills
    run_op("R5 byte wrap", ones, {16{8'h01}}, 2'd0, 2'd0, '0);
    run_op("R5 half wrap", ones, {8{16'h0001}}, 2'd1, 2'd0, '0);
    // R6 R10
    run_op("R6 wrap", {16{8'hf0}}, {16{8'h20}}, 2'd0, 2'd0, {16{8'h10}});
    run_op("R10 alt wrap", {16{8'hf0}}, {16{8'h20}}, 2'd0, 2'd3, {16{8'h10}});
    // R7 signed both directions
    run_op("R7 pos clamp", {16{8'h7f}}, {16{8'h01}}, 2'd0, 2'd1, {16{8'h7f}});
    run_op("R7 neg clamp", {16{8'h80}}, {16{8'h80}}, 2'd0, 2'd1, {16{8'h80}});
    run_op("R7 half neg", {8{16'h8000}}, {8{16'hffff}}, 2'd1, 2'd1, {8{16'h8000}});
    run_op("R7 dword pos", {4{32'h7fff_fff0}}, {4{32'h0000_0100}}, 2'd2, 2'd1,
           {4{32'h7fff_ffff}});
    run_op("R7 qword neg", {2{64'h8000_0000_0000_0001}}, {2{64'hc000_0000_0000_0000}}, 2'd3,
           2'd1, {2{64'h8000_0000_0000_0000}});
    run_op("R7 no ovf", {16{8'h7f}}, {16{8'hff}}, 2'd0, 2'd1, {16{8'h7e}});
    // R8 R9
    run_op("R8 ucl byte", {16{8'hff}}, {16{8'h01}}, 2'd0, 2'd2, {16{8'hff}});
    run_op("R8 ucl dword", {4{32'hffff_ffff}}, {4{32'h0000_0001}}, 2'd2, 2'd2,
           {4{32'hffff_ffff}});
    run_op("R9 ufit", {4{32'h0000_0001}}, {4{32'h0000_0002}}, 2'd2, 2'd2, {4{32'h0000_0003}});
    run_op("R9 ufit qword", {2{64'h7fff_ffff_ffff_ffff}}, {2{64'h8000_0000_0000_0000}}, 2'd3,
           2'd2, '1);

    // random: R4 R5 R6 R7 R8 R9 R10 against the reference model
    for (int i = 0; i < 600; i++) begin
      logic [DW-1:0] a, b;
      logic [1:0]    w, m;
      a = rnd_vec();
      b = rnd_vec();
      w = 2'($urandom);
      m = 2'($urandom);
      run_op("R4-mix random", a, b, w, m, ref_add(a, b, w, m));
    end

    // back-to-back stream, R2
    for (int i = 0; i < 50; i++) begin
      logic [DW-1:0] a, b;
      logic [1:0]    w, m;
      a = rnd_vec(); b = rnd_vec(); w = 2'($urandom); m = 2'($urandom);
      @(negedge clk_i);
      if (i > 0) begin
        check("R2 stream valid", DW'(out_valid_o), DW'(1));
      end
      a_i = a; b_i = b; width_i = w; mode_i = m; in_valid_i = 1'b1;
      @(negedge clk_i);
      check("R2 stream data", result_o, ref_add(a, b, w, m));
      in_valid_i = (i != 49);
    end
    in_valid_i = 1'b0;
    @(negedge clk_i);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule